// File: doc/BRIEF.md
# Microcode Sequencer Next-Address Unit

This block is the sequencing heart of a microprogrammed controller. It keeps the current microaddress in a register. It reads the microinstruction at that address from a control store whose contents are fixed at elaboration by a parameter image. Every cycle it drives the control-signal field of that microinstruction to the datapath. Each microinstruction also carries a 3-bit jump-kind field and an absolute target field. Together with the memory busy flag, the datapath zero flag and the instruction opcode, these fields decide the microaddress for the next cycle.

Opcodes do not index the store directly. A separate opcode map, also a parameter image, turns each opcode into the entry microaddress of its operation group, or marks the opcode as having no group. This keeps the store's height set by the number of microsteps rather than by the opcode and status bits. The datapath, the memory and the macro-level register file are outside this block.

Top module: `uaddr_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, the microaddress becomes 0. After reset, `ctrl_out` shows the control field of store entry 0.
- R2: Jump kind 0 (advance) loads the current microaddress plus one. The address wraps from the last store entry to entry 0.
- R3: Jump kind 1 (wait) keeps the microaddress unchanged while `mem_busy` is high. When `mem_busy` is low it advances by one.
- R4: Jump kind 2 (restart) loads the parameter `FETCH_ADDR`, whatever the flags and opcode are.
- R5: Jump kind 3 (decode) loads the entry microaddress that the opcode map gives for `opcode`, when that map entry is marked valid. Each map entry is packed as {valid bit, entry address}, at offset opcode*(AW+1).
- R6: Jump kind 3 with an opcode whose map entry is not valid loads the parameter `ILL_ADDR`.
- R7: Jump kind 4 (branch on zero) loads the microinstruction's target field when `alu_zero` is high. Otherwise it advances by one.
- R8: Jump kind 5 (branch on non-zero) advances by one when `alu_zero` is high. Otherwise it loads the target field.
- R9: Jump kinds 6 and 7 behave exactly like kind 0.
- R10: `ctrl_out` always equals the control field of the store entry at the current microaddress. Each store word is packed as {control[CW-1:0], kind[2:0], target[AW-1:0]}, at offset address*(CW+3+AW).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_busy | input | 1 | Memory still working; holds a wait step |
| alu_zero | input | 1 | Datapath zero flag for the conditional branches |
| opcode | input | OPW (6) | Instruction opcode used by the decode jump |
| ctrl_out | output | CW (17) | Control field of the current microinstruction |

## Verification
The hardest cases to reach from the ports are the rare ones. These are an invalid opcode arriving exactly when a decode step is active, and the wrap from the top store entry back to 0. Both depend on where the microaddress already is, and that address is only visible through `ctrl_out`. The bench therefore loads its own store image, in which every control field encodes its own address, so that each step can be tracked. It then walks directed opcode sequences to steer a decode step onto the top entry and onto an unmapped opcode. It also holds `mem_busy` over several wait cycles. Random flags and opcodes follow, and the branch kinds are reached through decode jumps.

// File: rtl/uaddr_pkg.sv
package uaddr_pkg;

    localparam int UA_AW_DEF  = 6;
    localparam int UA_CW_DEF  = 17;
    localparam int UA_OPW_DEF = 6;
    localparam int UA_UIW_DEF = UA_CW_DEF + 3 + UA_AW_DEF;

    typedef enum logic [2:0] {
        JT_NEXT  = 3'd0,
        JT_SPIN  = 3'd1,
        JT_FETCH = 3'd2,
        JT_DISP  = 3'd3,
        JT_FEQZ  = 3'd4,
        JT_FNEZ  = 3'd5
    } ujump_e;

    // Default store: straight-line groups of four steps, each ending in a restart.
    function automatic logic [(2**UA_AW_DEF)*UA_UIW_DEF-1:0] ua_default_urom();
        logic [(2**UA_AW_DEF)*UA_UIW_DEF-1:0] img;
        img = '0;
        for (int i = 0; i < 2**UA_AW_DEF; i++) begin
            img[i*UA_UIW_DEF +: UA_UIW_DEF] = {
                UA_CW_DEF'(i),
                ((i % 4) == 3) ? JT_FETCH : JT_NEXT,
                UA_AW_DEF'(0)
            };
        end
        return img;
    endfunction

    // Default opcode map: every opcode valid, groups on four-step boundaries.
    function automatic logic [(2**UA_OPW_DEF)*(UA_AW_DEF+1)-1:0] ua_default_disp();
        logic [(2**UA_OPW_DEF)*(UA_AW_DEF+1)-1:0] img;
        img = '0;
        for (int o = 0; o < 2**UA_OPW_DEF; o++) begin
            img[o*(UA_AW_DEF+1) +: UA_AW_DEF+1] = {1'b1, UA_AW_DEF'((o % 16) * 4)};
        end
        return img;
    endfunction

endpackage

// File: rtl/uaddr_store.sv
module uaddr_store #(
    parameter int AW = 6,
    parameter int CW = 17,
    parameter logic [(2**AW)*(CW+3+AW)-1:0] IMG = '0
) (
    input  logic [AW-1:0] addr,
    output logic [CW-1:0] ctrl,
    output logic [2:0]    jkind,
    output logic [AW-1:0] target
);
    localparam int DEPTH = 2**AW;
    localparam int UIW   = CW + 3 + AW;

    logic [UIW-1:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        assign words[g] = IMG[g*UIW +: UIW];
    end

    logic [UIW-1:0] sel;

    always_comb begin
        sel    = words[addr];
        ctrl   = sel[UIW-1 -: CW];
        jkind  = sel[AW +: 3];
        target = sel[AW-1:0];
    end
endmodule

// File: rtl/uaddr_dispatch.sv
module uaddr_dispatch #(
    parameter int OPW = 6,
    parameter int AW  = 6,
    parameter logic [(2**OPW)*(AW+1)-1:0] IMG = '0
) (
    input  logic [OPW-1:0] opcode,
    output logic           hit,
    output logic [AW-1:0]  entry
);
    localparam int NOPS = 2**OPW;
    localparam int EW   = AW + 1;

    logic [EW-1:0] slots [NOPS];

    for (genvar g = 0; g < NOPS; g++) begin : g_slot
        assign slots[g] = IMG[g*EW +: EW];
    end

    always_comb begin
        hit   = slots[opcode][AW];
        entry = slots[opcode][AW-1:0];
    end
endmodule

// File: rtl/uaddr_nextsel.sv
module uaddr_nextsel
    import uaddr_pkg::*;
#(
    parameter int AW = 6,
    parameter logic [AW-1:0] FETCH_ADDR = '0,
    parameter logic [AW-1:0] ILL_ADDR   = '1
) (
    input  logic [AW-1:0] cur,
    input  logic [2:0]    jkind,
    input  logic          busy,
    input  logic          zero,
    input  logic [AW-1:0] target,
    input  logic          disp_hit,
    input  logic [AW-1:0] disp_entry,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] incr;

    always_comb begin
        incr = cur + AW'(1);
        case (jkind)
            JT_SPIN:  nxt = busy ? cur : incr;
            JT_FETCH: nxt = FETCH_ADDR;
            JT_DISP:  nxt = disp_hit ? disp_entry : ILL_ADDR;
            JT_FEQZ:  nxt = zero ? target : incr;
            JT_FNEZ:  nxt = zero ? incr : target;
            default:  nxt = incr;
        endcase
    end
endmodule

// File: rtl/uaddr_seq.sv
module uaddr_seq
    import uaddr_pkg::*;
#(
    parameter int AW  = UA_AW_DEF,
    parameter int CW  = UA_CW_DEF,
    parameter int OPW = UA_OPW_DEF,
    parameter logic [AW-1:0] FETCH_ADDR = '0,
    parameter logic [AW-1:0] ILL_ADDR   = '1,
    parameter logic [(2**AW)*(CW+3+AW)-1:0] UROM_IMG = ua_default_urom(),
    parameter logic [(2**OPW)*(AW+1)-1:0]   DISP_IMG = ua_default_disp()
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           mem_busy,
    input  logic           alu_zero,
    input  logic [OPW-1:0] opcode,
    output logic [CW-1:0]  ctrl_out
);
    typedef struct packed {
        logic [AW-1:0] uaddr;
    } seq_state_t;

    seq_state_t state_d, state_q;

    logic [AW-1:0] cur_addr;
    logic [2:0]    cur_jt;
    logic [AW-1:0] cur_tgt;
    logic          disp_hit;
    logic [AW-1:0] disp_ent;
    logic [AW-1:0] nxt_addr;

    assign cur_addr = state_q.uaddr;

    uaddr_store #(.AW(AW), .CW(CW), .IMG(UROM_IMG)) u_store (
        .addr   (cur_addr),
        .ctrl   (ctrl_out),
        .jkind  (cur_jt),
        .target (cur_tgt)
    );

    uaddr_dispatch #(.OPW(OPW), .AW(AW), .IMG(DISP_IMG)) u_disp (
        .opcode (opcode),
        .hit    (disp_hit),
        .entry  (disp_ent)
    );

    uaddr_nextsel #(.AW(AW), .FETCH_ADDR(FETCH_ADDR), .ILL_ADDR(ILL_ADDR)) u_nsel (
        .cur        (cur_addr),
        .jkind      (cur_jt),
        .busy       (mem_busy),
        .zero       (alu_zero),
        .target     (cur_tgt),
        .disp_hit   (disp_hit),
        .disp_entry (disp_ent),
        .nxt        (nxt_addr)
    );

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.uaddr = '0;
        end else begin
            state_d.uaddr = nxt_addr;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end
endmodule

// File: rtl/uaddr_seq_chk.sv
module uaddr_seq_chk
    import uaddr_pkg::*;
#(
    parameter int AW = 6,
    parameter logic [AW-1:0] FETCH_ADDR = '0,
    parameter logic [AW-1:0] ILL_ADDR   = '1
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          zero,
    input logic [AW-1:0] cur_addr,
    input logic [2:0]    cur_jt,
    input logic [AW-1:0] cur_tgt,
    input logic          disp_hit,
    input logic [AW-1:0] disp_ent
);
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> cur_addr == '0);

    p_advance_r2: assert property (@(posedge clk) disable iff (rst)
        cur_jt == JT_NEXT |=> cur_addr == $past(cur_addr) + AW'(1));

    p_wait_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (cur_jt == JT_SPIN && busy) |=> $stable(cur_addr));

    p_restart_r4: assert property (@(posedge clk) disable iff (rst)
        cur_jt == JT_FETCH |=> cur_addr == FETCH_ADDR);

    p_decode_hit_r5: assert property (@(posedge clk) disable iff (rst)
        (cur_jt == JT_DISP && disp_hit) |=> cur_addr == $past(disp_ent));

    p_decode_miss_r6: assert property (@(posedge clk) disable iff (rst)
        (cur_jt == JT_DISP && !disp_hit) |=> cur_addr == ILL_ADDR);

    p_brz_taken_r7: assert property (@(posedge clk) disable iff (rst)
        (cur_jt == JT_FEQZ && zero) |=> cur_addr == $past(cur_tgt));

    p_brnz_taken_r8: assert property (@(posedge clk) disable iff (rst)
        (cur_jt == JT_FNEZ && !zero) |=> cur_addr == $past(cur_tgt));

    p_spare_kind_r9: assert property (@(posedge clk) disable iff (rst)
        (cur_jt[2:1] == 2'b11) |=> cur_addr == $past(cur_addr) + AW'(1));
endmodule

bind uaddr_seq uaddr_seq_chk #(.AW(AW), .FETCH_ADDR(FETCH_ADDR), .ILL_ADDR(ILL_ADDR)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (mem_busy),
    .zero     (alu_zero),
    .cur_addr (cur_addr),
    .cur_jt   (cur_jt),
    .cur_tgt  (cur_tgt),
    .disp_hit (disp_hit),
    .disp_ent (disp_ent)
);

// File: tb/uaddr_seq_test.sv
`timescale 1ns/1ps
module uaddr_seq_test;
    localparam int AW = 6, CW = 17, OPW = 6;
    localparam int DEPTH = 2**AW, NOPS = 2**OPW, UIW = CW + 3 + AW;
    localparam logic [AW-1:0] FETCH_A = 6'd0;
    localparam logic [AW-1:0] ILL_A   = 6'd62;

    function automatic logic [2:0] f_jt(int a);
        return 3'((a * 5 + 3) % 8);
    endfunction
    function automatic logic [AW-1:0] f_tgt(int a);
        return AW'((a * 11 + 7) % DEPTH);
    endfunction
    function automatic logic [CW-1:0] f_ctrl(int a);
        return {5'(a[4:0] ^ 5'h15), 6'(~a[5:0]), 6'(a[5:0])};
    endfunction
    function automatic logic f_hit(int o);
        return (o % 5) != 0;
    endfunction
    function automatic logic [AW-1:0] f_ent(int o);
        return AW'((o * 13 + 1) % DEPTH);
    endfunction

    function automatic logic [DEPTH*UIW-1:0] mk_rom();
        logic [DEPTH*UIW-1:0] img;
        img = '0;
        for (int i = 0; i < DEPTH; i++) img[i*UIW +: UIW] = {f_ctrl(i), f_jt(i), f_tgt(i)};
        return img;
    endfunction
    function automatic logic [NOPS*(AW+1)-1:0] mk_map();
        logic [NOPS*(AW+1)-1:0] img;
        img = '0;
        for (int o = 0; o < NOPS; o++) img[o*(AW+1) +: AW+1] = {f_hit(o), f_ent(o)};
        return img;
    endfunction

    localparam logic [DEPTH*UIW-1:0]     ROM_IMG = mk_rom();
    localparam logic [NOPS*(AW+1)-1:0]   MAP_IMG = mk_map();

    logic clk = 1'b0, rst = 1'b1, busy = 1'b0, zero = 1'b0;
    logic [OPW-1:0] op = '0;
    logic [CW-1:0] ctrl_out;

    always #2.5 clk = ~clk;

    uaddr_seq #(.AW(AW), .CW(CW), .OPW(OPW), .FETCH_ADDR(FETCH_A), .ILL_ADDR(ILL_A),
                .UROM_IMG(ROM_IMG), .DISP_IMG(MAP_IMG)) uut (
        .clk(clk), .rst(rst), .mem_busy(busy), .alu_zero(zero), .opcode(op), .ctrl_out(ctrl_out)
    );

    int checks = 0, errors = 0;
    int seen [8];
    logic [AW-1:0] exp_addr;

    task automatic check(string req, logic [CW-1:0] act, logic [CW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] f_next(logic [AW-1:0] a, logic b, logic z, logic [OPW-1:0] o);
        case (f_jt(int'(a)))
            3'd1: return b ? a : a + 6'd1;
            3'd2: return FETCH_A;
            3'd3: return f_hit(int'(o)) ? f_ent(int'(o)) : ILL_A;
            3'd4: return z ? f_tgt(int'(a)) : a + 6'd1;
            3'd5: return z ? a + 6'd1 : f_tgt(int'(a));
            default: return a + 6'd1;
        endcase
    endfunction

    function automatic string f_req(logic [AW-1:0] a, logic [OPW-1:0] o);
        case (f_jt(int'(a)))
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return f_hit(int'(o)) ? "R5" : "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Called right after a falling edge; samples at the following falling edge.
    task automatic step(logic b, logic z, logic [OPW-1:0] o);
        logic [AW-1:0] nx;
        string req;
        busy = b; zero = z; op = o;
        nx  = f_next(exp_addr, b, z, o);
        req = f_req(exp_addr, o);
        seen[f_jt(int'(exp_addr))]++;
        @(negedge clk);
        check({req, "/R10"}, ctrl_out, f_ctrl(int'(nx)));
        exp_addr = nx;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_addr = '0;
        check("R1", ctrl_out, f_ctrl(0));
    endtask

    bit done = 0;

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        do_reset();
        // R5: decode to the top entry, then R9 wrap of kind 6 back to 0 (also R2 wrap rule)
        step(1'b0, 1'b0, 6'd54);
        step(1'b1, 1'b1, 6'd7);
        // R6: unmapped opcode 0 goes to the illegal entry
        step(1'b0, 1'b0, 6'd0);
        // R3: hold on busy, then release
        step(1'b1, 1'b0, 6'd3);
        step(1'b1, 1'b1, 6'd9);
        step(1'b1, 1'b0, 6'd40);
        step(1'b0, 1'b0, 6'd0);
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] & r[1], r[2], OPW'(r[13:8]));
            if (n == 1500) do_reset();   // R1 mid-run
        end
        for (int k = 0; k < 8; k++) begin
            checks++;
            if (seen[k] == 0) begin
                errors++;
                $display("FAIL coverage kind %0d actual 0 expected >0 (R2..R9)", k);
            end
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule